// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block arbitrates among thirty-two external interrupt lines, a non-maskable request and a hard-fault request, and decides when the winner may take over from the code that is running. Each external line has an enable bit and a two-bit urgency level, both set through a small write port. The non-maskable and hard-fault requests have fixed levels that rank above every configurable level.

When a pending source is strictly more urgent than the running priority, the controller enters a counted context-save phase of eight cycles, one for each saved word. During this phase it shows the vector fetch address of its current target. It then pushes the handler onto a nesting stack. An exception-return strobe from the core either restores the interrupted context through a counted eight-cycle restore phase, or chains straight into a pending handler that may run at the restored priority. A more urgent request that arrives during context save takes over the target without restarting the save.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous reset, `phase` is 0, `act_exc` is 0 (thread), `vec_addr` is 0, every line is disabled and every configurable level is 0.
- R2: A pending flag is set only by a rising edge of a line whose enable bit is 1 at that edge. A disabled line never enters arbitration, and enabling it later does not create a pending request. A line held high does not pend again after its handler has been entered.
- R3: Ranking from most to least urgent: non-maskable (exception 2), hard fault (exception 3), then configurable levels 0, 1, 2 and 3. Among sources of equal rank, the lowest exception number wins.
- R4: Line n is exception 16+n. Exception numbers are shown on `act_exc`. `vec_addr` equals the exception number times 4, so exception 2 gives 0x08, exception 3 gives 0x0C and line n gives (16+n)*4.
- R5: A pending source preempts only if its rank is strictly more urgent than the rank of the running handler (thread ranks below every source). Equal or lower ranks stay pending.
- R6: `phase` encodes 0 = executing, 1 = context save, 2 = context restore. Context save and context restore each last exactly 8 cycles. `act_exc` changes to the new handler when context save ends, and back to the interrupted one when context restore ends.
- R7: On an exception return, if the best pending source outranks the priority that would be restored, the next cycle shows that handler in phase 0, with no restore phase and no save phase.
- R8: A more urgent arrival during context save retargets the entry. The save phase keeps its total length of 8 cycles, and the earlier target stays pending.
- R9: Preemptions nest. Each return restores the interrupted handler's number and vector address.
- R10: An exception-return strobe while in thread state is ignored.
- R11: `cfg_en_we` writes `cfg_en` and `cfg_prio_we` writes `cfg_prio` for line `cfg_idx`, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_we | input | 1 | Write strobe for the enable bit |
| cfg_prio_we | input | 1 | Write strobe for the urgency level |
| cfg_idx | input | 5 | Line selected by the write port |
| cfg_en | input | 1 | Enable value to write |
| cfg_prio | input | 2 | Urgency level to write (0 most urgent) |
| irq_in | input | 32 | External interrupt lines |
| nmi_in | input | 1 | Non-maskable request, edge-detected |
| hf_in | input | 1 | Hard-fault request, edge-detected |
| exc_return | input | 1 | Handler-done strobe from the core |
| phase | output | 2 | 0 executing, 1 context save, 2 context restore |
| act_exc | output | 6 | Active exception number, 0 in thread |
| vec_addr | output | 32 | Vector fetch address of target or active handler |

## Verification
The bench targets equal-rank arrivals during a running handler: a design using a non-strict comparison would nest there instead of leaving them pending. Ties between simultaneous sources check that the lowest number wins, and a reversed scan would enter the higher line first. The late-arrival test injects the non-maskable request in the middle of context save and checks that the phase still ends after eight cycles and that the displaced line then follows by tail chaining; a design that restarted stacking would show a longer phase. Returns with and without a pending successor expose a controller that unstacks when it should chain. A controller that failed to clear pending flags, or that kept disabled edges, would re-enter the line or take it after enable.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
package irq_nest_pkg;
  typedef enum logic [1:0] {
    PH_EXEC    = 2'd0,
    PH_STACK   = 2'd1,
    PH_UNSTACK = 2'd2
  } phase_e;

  localparam int EXC_NMI  = 2;
  localparam int EXC_HF   = 3;
  localparam int EXC_IRQ0 = 16;
endpackage

// File: rtl/irq_src_unit.sv
`timescale 1ns/1ps
module irq_src_unit import irq_nest_pkg::*; #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  localparam int NUM_EXC = EXC_IRQ0 + NUM_IRQ,
  localparam int EXC_W   = $clog2(NUM_EXC),
  localparam int IDX_W   = $clog2(NUM_IRQ),
  localparam int RANK_W  = PRIO_W + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_en_we,
  input  logic                      cfg_prio_we,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic                      cfg_en,
  input  logic [PRIO_W-1:0]         cfg_prio,
  input  logic [NUM_IRQ-1:0]        irq_in,
  input  logic                      nmi_in,
  input  logic                      hf_in,
  input  logic                      clr_valid,
  input  logic [EXC_W-1:0]          clr_num,
  output logic [NUM_IRQ-1:0]        en_vec,
  output logic [NUM_EXC-1:0]        pend_exc,
  output logic [NUM_EXC*RANK_W-1:0] rank_flat
);
  logic [NUM_IRQ-1:0]             en_q, line_q, pend_q;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
  logic                           nmi_q, hf_q, nmi_pend_q, hf_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      line_q     <= '0;
      pend_q     <= '0;
      prio_q     <= '0;
      nmi_q      <= 1'b0;
      hf_q       <= 1'b0;
      nmi_pend_q <= 1'b0;
      hf_pend_q  <= 1'b0;
    end else begin
      line_q <= irq_in;
      nmi_q  <= nmi_in;
      hf_q   <= hf_in;
      if (cfg_en_we)   en_q[cfg_idx]   <= cfg_en;
      if (cfg_prio_we) prio_q[cfg_idx] <= cfg_prio;
      for (int i = 0; i < NUM_IRQ; i++) begin
        pend_q[i] <= (pend_q[i] && !(clr_valid && clr_num == EXC_W'(EXC_IRQ0 + i)))
                     || (irq_in[i] && !line_q[i] && en_q[i]);
      end
      nmi_pend_q <= (nmi_pend_q && !(clr_valid && clr_num == EXC_W'(EXC_NMI)))
                    || (nmi_in && !nmi_q);
      hf_pend_q  <= (hf_pend_q && !(clr_valid && clr_num == EXC_W'(EXC_HF)))
                    || (hf_in && !hf_q);
    end
  end

  assign en_vec = en_q;

  for (genvar e = 0; e < NUM_EXC; e++) begin : g_src
    if (e == EXC_NMI) begin : g_nmi
      assign pend_exc[e] = nmi_pend_q;
      assign rank_flat[e*RANK_W +: RANK_W] = RANK_W'(0);
    end else if (e == EXC_HF) begin : g_hf
      assign pend_exc[e] = hf_pend_q;
      assign rank_flat[e*RANK_W +: RANK_W] = RANK_W'(1);
    end else if (e >= EXC_IRQ0) begin : g_irq
      assign pend_exc[e] = pend_q[e-EXC_IRQ0] && en_q[e-EXC_IRQ0];
      assign rank_flat[e*RANK_W +: RANK_W] = RANK_W'(prio_q[e-EXC_IRQ0]) + RANK_W'(2);
    end else begin : g_none
      assign pend_exc[e] = 1'b0;
      assign rank_flat[e*RANK_W +: RANK_W] = '1;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int NUM_EXC = 48,
  parameter int RANK_W  = 4,
  localparam int EXC_W  = $clog2(NUM_EXC)
) (
  input  logic [NUM_EXC-1:0]        pend_exc,
  input  logic [NUM_EXC*RANK_W-1:0] rank_flat,
  output logic                      win_valid,
  output logic [EXC_W-1:0]          win_num,
  output logic [RANK_W-1:0]         win_rank
);
  always_comb begin
    win_valid = 1'b0;
    win_num   = '0;
    win_rank  = '1;
    for (int e = 0; e < NUM_EXC; e++) begin
      if (pend_exc[e] && (!win_valid || rank_flat[e*RANK_W +: RANK_W] < win_rank)) begin
        win_valid = 1'b1;
        win_num   = EXC_W'(e);
        win_rank  = rank_flat[e*RANK_W +: RANK_W];
      end
    end
  end
endmodule

// File: rtl/exc_nest_stack.sv
`timescale 1ns/1ps
module exc_nest_stack #(
  parameter int DEPTH = 6,
  parameter int EXC_W = 6,
  localparam int DEP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             replace,
  input  logic [EXC_W-1:0] din,
  output logic [EXC_W-1:0] top_num,
  output logic [EXC_W-1:0] under_num,
  output logic [DEP_W-1:0] depth
);
  logic [EXC_W-1:0] mem [DEPTH];
  logic [DEP_W-1:0] depth_q;

  always_ff @(posedge clk) begin
    if (push && depth_q < DEP_W'(DEPTH)) mem[depth_q] <= din;
    else if (replace && depth_q != '0)   mem[depth_q - DEP_W'(1)] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) depth_q <= '0;
    else if (push && depth_q < DEP_W'(DEPTH)) depth_q <= depth_q + DEP_W'(1);
    else if (pop && depth_q != '0)            depth_q <= depth_q - DEP_W'(1);
  end

  assign top_num   = (depth_q == '0)      ? '0 : mem[depth_q - DEP_W'(1)];
  assign under_num = (depth_q < DEP_W'(2)) ? '0 : mem[depth_q - DEP_W'(2)];
  assign depth     = depth_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
module irq_nest_ctrl import irq_nest_pkg::*; #(
  parameter int NUM_IRQ    = 32,
  parameter int PRIO_W     = 2,
  parameter int CTX_WORDS  = 8,
  parameter int NEST_DEPTH = 6,
  parameter int ADDR_W     = 32,
  localparam int NUM_EXC = EXC_IRQ0 + NUM_IRQ,
  localparam int EXC_W   = $clog2(NUM_EXC),
  localparam int IDX_W   = $clog2(NUM_IRQ),
  localparam int RANK_W  = PRIO_W + 2,
  localparam int CNT_W   = $clog2(CTX_WORDS),
  localparam int DEP_W   = $clog2(NEST_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en_we,
  input  logic               cfg_prio_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_en,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  input  logic               hf_in,
  input  logic               exc_return,
  output logic [1:0]         phase,
  output logic [EXC_W-1:0]   act_exc,
  output logic [ADDR_W-1:0]  vec_addr
);
  logic [NUM_IRQ-1:0]        en_vec;
  logic [NUM_EXC-1:0]        pend_exc;
  logic [NUM_EXC*RANK_W-1:0] rank_flat;
  logic                      win_valid;
  logic [EXC_W-1:0]          win_num;
  logic [RANK_W-1:0]         win_rank;
  logic [EXC_W-1:0]          top_num, under_num;
  logic [DEP_W-1:0]          depth;

  phase_e              state_q, state_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [EXC_W-1:0]    tgt_q, tgt_n, act_q, act_n, clr_num, push_num;
  logic [ADDR_W-1:0]   vec_q, vec_n;
  logic                push, pop, replace, clr_valid, retarget;
  logic [RANK_W-1:0]   cur_rank, rest_rank, tgt_rank;

  function automatic logic [ADDR_W-1:0] vec_of(input logic [EXC_W-1:0] n);
    return ADDR_W'(n) << 2;
  endfunction

  irq_src_unit #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_src (
    .clk, .rst, .cfg_en_we, .cfg_prio_we, .cfg_idx, .cfg_en, .cfg_prio,
    .irq_in, .nmi_in, .hf_in, .clr_valid, .clr_num,
    .en_vec, .pend_exc, .rank_flat
  );

  irq_arbiter #(.NUM_EXC(NUM_EXC), .RANK_W(RANK_W)) u_arb (
    .pend_exc, .rank_flat, .win_valid, .win_num, .win_rank
  );

  exc_nest_stack #(.DEPTH(NEST_DEPTH), .EXC_W(EXC_W)) u_stk (
    .clk, .rst, .push, .pop, .replace, .din(push_num),
    .top_num, .under_num, .depth
  );

  // exception 0 (thread) maps to an all-ones rank in the source unit
  assign cur_rank  = rank_flat[top_num*RANK_W +: RANK_W];
  assign rest_rank = rank_flat[under_num*RANK_W +: RANK_W];
  assign tgt_rank  = rank_flat[tgt_q*RANK_W +: RANK_W];

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    tgt_n     = tgt_q;
    act_n     = act_q;
    vec_n     = vec_q;
    push      = 1'b0;
    pop       = 1'b0;
    replace   = 1'b0;
    clr_valid = 1'b0;
    clr_num   = win_num;
    push_num  = win_num;
    retarget  = win_valid && win_rank < tgt_rank;
    unique case (state_q)
      PH_EXEC: begin
        if (exc_return && depth != '0) begin
          if (win_valid && win_rank < rest_rank) begin
            replace   = 1'b1;
            clr_valid = 1'b1;
            act_n     = win_num;
            vec_n     = vec_of(win_num);
          end else begin
            state_n = PH_UNSTACK;
            cnt_n   = '0;
          end
        end else if (win_valid && win_rank < cur_rank) begin
          state_n = PH_STACK;
          cnt_n   = '0;
          tgt_n   = win_num;
          vec_n   = vec_of(win_num);
        end
      end
      PH_STACK: begin
        if (retarget) begin
          tgt_n = win_num;
          vec_n = vec_of(win_num);
        end
        if (cnt_q == CNT_W'(CTX_WORDS - 1)) begin
          push      = 1'b1;
          push_num  = tgt_n;
          clr_valid = 1'b1;
          clr_num   = tgt_n;
          act_n     = tgt_n;
          state_n   = PH_EXEC;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      PH_UNSTACK: begin
        if (cnt_q == CNT_W'(CTX_WORDS - 1)) begin
          pop     = 1'b1;
          act_n   = under_num;
          vec_n   = vec_of(under_num);
          state_n = PH_EXEC;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      default: state_n = PH_EXEC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_EXEC;
      cnt_q   <= '0;
      tgt_q   <= '0;
      act_q   <= '0;
      vec_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      tgt_q   <= tgt_n;
      act_q   <= act_n;
      vec_q   <= vec_n;
    end
  end

  assign phase    = state_q;
  assign act_exc  = act_q;
  assign vec_addr = vec_q;
endmodule

// File: rtl/irq_nest_chk.sv
`timescale 1ns/1ps
module irq_nest_chk #(
  parameter int NUM_IRQ   = 32,
  parameter int EXC_W     = 6,
  parameter int ADDR_W    = 32,
  parameter int CTX_WORDS = 8,
  localparam int IDX_W    = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         phase,
  input logic [EXC_W-1:0]   act_exc,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic               exc_return,
  input logic               win_valid,
  input logic [EXC_W-1:0]   win_num,
  input logic [NUM_IRQ-1:0] en_vec
);
  logic [7:0] save_len, rest_len;
  logic       was_save, was_rest;

  always_ff @(posedge clk) begin
    if (rst) begin
      save_len <= '0;
      rest_len <= '0;
      was_save <= 1'b0;
      was_rest <= 1'b0;
    end else begin
      save_len <= (phase == 2'd1) ? save_len + 8'd1 : 8'd0;
      rest_len <= (phase == 2'd2) ? rest_len + 8'd1 : 8'd0;
      was_save <= (phase == 2'd1);
      was_rest <= (phase == 2'd2);
    end
  end

  // R6: context save runs exactly CTX_WORDS cycles, late arrival included (R8)
  p_save_len_r6: assert property (@(posedge clk) disable iff (rst)
    (was_save && phase != 2'd1) |-> save_len == 8'(CTX_WORDS));

  // R6: context restore runs exactly CTX_WORDS cycles
  p_rest_len_r6: assert property (@(posedge clk) disable iff (rst)
    (was_rest && phase != 2'd2) |-> rest_len == 8'(CTX_WORDS));

  // R7: a restore never leads straight into a new save
  p_no_restack_r7: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd2 |=> phase != 2'd1);

  // R4: while executing, the vector matches the active exception
  p_vec_match_r4: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd0 |-> vec_addr == (ADDR_W'(act_exc) << 2));

  // R2: only fixed sources or enabled lines win arbitration
  p_enabled_only_r2: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_num == EXC_W'(2) || win_num == EXC_W'(3) ||
                   (win_num >= EXC_W'(16) && en_vec[IDX_W'(win_num - EXC_W'(16))])));

  // R10: a return strobe in thread state starts no restore
  p_idle_return_r10: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && act_exc == '0 && exc_return) |=> phase != 2'd2);
endmodule

bind irq_nest_ctrl irq_nest_chk #(
  .NUM_IRQ(NUM_IRQ), .EXC_W(EXC_W), .ADDR_W(ADDR_W), .CTX_WORDS(CTX_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .act_exc(act_exc), .vec_addr(vec_addr),
  .exc_return(exc_return), .win_valid(win_valid), .win_num(win_num), .en_vec(en_vec)
);

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en_we = 1'b0, cfg_prio_we = 1'b0, cfg_en = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [1:0]  cfg_prio = '0;
  logic [31:0] irq_in = '0;
  logic        nmi_in = 1'b0, hf_in = 1'b0, exc_return = 1'b0;
  logic [1:0]  phase;
  logic [5:0]  act_exc;
  logic [31:0] vec_addr;

  int n_chk = 0, n_fail = 0, n;
  bit done = 1'b0;

  localparam int NT = 6;
  localparam int TBL_IDX  [NT] = '{0, 5, 17, 31, 12, 26};
  localparam int TBL_PRIO [NT] = '{3, 2, 1, 0, 2, 1};

  always #10 clk = ~clk;

  irq_nest_ctrl dut (
    .clk, .rst, .cfg_en_we, .cfg_prio_we, .cfg_idx, .cfg_en, .cfg_prio,
    .irq_in, .nmi_in, .hf_in, .exc_return, .phase, .act_exc, .vec_addr
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic steps(input int k); repeat (k) @(negedge clk); endtask

  task automatic cfg(input int idx, input bit en, input int prio);
    cfg_idx = 5'(idx); cfg_en = en; cfg_prio = 2'(prio);
    cfg_en_we = 1'b1; cfg_prio_we = 1'b1;
    step();
    cfg_en_we = 1'b0; cfg_prio_we = 1'b0;
  endtask

  task automatic ret();
    exc_return = 1'b1; step(); exc_return = 1'b0;
  endtask

  task automatic count_phase(input logic [1:0] ph, output int cnt);
    cnt = 0;
    while (phase == ph && cnt < 100) begin cnt++; step(); end
  endtask

  // raise happened at this negedge; enter and check the save length
  task automatic enter(input string req, input int exp_num);
    int c;
    steps(2);
    check({req, " save phase"}, int'(phase), 1);
    count_phase(2'd1, c);
    check({req, " save cycles"}, c, 8);
    check({req, " act"}, int'(act_exc), exp_num);
    check({req, " vec"}, int'(vec_addr), exp_num * 4);
  endtask

  task automatic leave(input string req, input int exp_num);
    int c;
    ret();
    check({req, " restore phase"}, int'(phase), 2);
    count_phase(2'd2, c);
    check({req, " restore cycles"}, c, 8);
    check({req, " act after restore"}, int'(act_exc), exp_num);
    check({req, " vec after restore"}, int'(vec_addr), exp_num * 4);
  endtask

  task automatic chain(input string req, input int exp_num);
    ret();
    check({req, " chain phase"}, int'(phase), 0);
    check({req, " chain act"}, int'(act_exc), exp_num);
    check({req, " chain vec"}, int'(vec_addr), exp_num * 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    steps(3);
    rst = 1'b0;
    step();
    // R1: reset state
    check("R1 phase", int'(phase), 0);
    check("R1 act", int'(act_exc), 0);
    check("R1 vec", int'(vec_addr), 0);
    // R1: lines come out of reset disabled
    irq_in[0] = 1'b1; steps(4);
    check("R1 disabled after reset", int'(phase), 0);
    check("R1 no entry", int'(act_exc), 0);
    irq_in[0] = 1'b0; step();

    // R4/R6/R11: table of single-line entries and exits
    for (int t = 0; t < NT; t++) begin
      cfg(TBL_IDX[t], 1'b1, TBL_PRIO[t]);
      irq_in[TBL_IDX[t]] = 1'b1;
      enter("R4 R6 table", 16 + TBL_IDX[t]);
      irq_in[TBL_IDX[t]] = 1'b0;
      leave("R6 R11 table", 0);
      cfg(TBL_IDX[t], 1'b0, 0);
    end

    // R10: return in thread state is ignored
    ret();
    check("R10 phase", int'(phase), 0);
    step();
    check("R10 phase later", int'(phase), 0);
    check("R10 act", int'(act_exc), 0);

    // R1 R11: level written 1 on line 13, line 9 only enabled (default level 0)
    cfg(13, 1'b1, 1);
    irq_in[13] = 1'b1;
    enter("R11 line13", 29);
    cfg_idx = 5'd9; cfg_en = 1'b1; cfg_prio = 2'd3; cfg_en_we = 1'b1; step(); cfg_en_we = 1'b0;
    irq_in[9] = 1'b1;
    enter("R1 default level preempts", 25);
    irq_in[9] = 1'b0; irq_in[13] = 1'b0;
    leave("R9 back to line13", 29);
    leave("R9 back to thread", 0);
    cfg(9, 1'b0, 0); cfg(13, 1'b0, 0);

    // R2: disabled edge not kept after enable
    irq_in[7] = 1'b1; steps(4);
    check("R2 disabled ignored", int'(phase), 0);
    cfg(7, 1'b1, 0); steps(4);
    check("R2 no pend after enable", int'(phase), 0);
    check("R2 act still thread", int'(act_exc), 0);
    irq_in[7] = 1'b0; cfg(7, 1'b0, 0);

    // R2: held level does not pend again
    cfg(8, 1'b1, 1);
    irq_in[8] = 1'b1;
    enter("R2 held line", 24);
    leave("R2 held line", 0);
    steps(4);
    check("R2 held no re-entry", int'(phase), 0);
    check("R2 held act", int'(act_exc), 0);
    irq_in[8] = 1'b0; cfg(8, 1'b0, 0);

    // R5 R7: equal level stays pending, then chains
    cfg(1, 1'b1, 3); cfg(3, 1'b1, 3);
    irq_in[1] = 1'b1;
    enter("R5 line1", 17);
    irq_in[3] = 1'b1; steps(4);
    check("R5 equal no preempt phase", int'(phase), 0);
    check("R5 equal no preempt act", int'(act_exc), 17);
    irq_in[1] = 1'b0; irq_in[3] = 1'b0;
    chain("R7 equal chains", 19);
    leave("R7 after chain", 0);

    // R9: nesting two deep
    cfg(2, 1'b1, 1);
    irq_in[1] = 1'b1;
    enter("R9 outer", 17);
    irq_in[2] = 1'b1;
    enter("R9 inner", 18);
    irq_in[1] = 1'b0; irq_in[2] = 1'b0;
    leave("R9 restore outer", 17);
    leave("R9 restore thread", 0);
    cfg(1, 1'b0, 0); cfg(2, 1'b0, 0); cfg(3, 1'b0, 0);

    // R3: tie at equal level, lowest number first
    cfg(4, 1'b1, 2); cfg(6, 1'b1, 2);
    irq_in[4] = 1'b1; irq_in[6] = 1'b1;
    enter("R3 tie", 20);
    irq_in[4] = 1'b0; irq_in[6] = 1'b0;
    chain("R3 tie second", 22);
    leave("R3 tie done", 0);
    cfg(4, 1'b0, 0); cfg(6, 1'b0, 0);

    // R3 R4: non-maskable over hard fault over level 0
    cfg(0, 1'b1, 0);
    nmi_in = 1'b1; hf_in = 1'b1; irq_in[0] = 1'b1;
    enter("R3 nmi first", 2);
    nmi_in = 1'b0; hf_in = 1'b0; irq_in[0] = 1'b0;
    chain("R3 hard fault next", 3);
    chain("R3 level0 last", 16);
    leave("R3 fixed done", 0);
    cfg(0, 1'b0, 0);

    // R8: late arrival retargets without lengthening the save
    cfg(5, 1'b1, 2);
    irq_in[5] = 1'b1;
    steps(2);
    check("R8 save started", int'(phase), 1);
    check("R8 early vec", int'(vec_addr), 21 * 4);
    steps(3);
    nmi_in = 1'b1;
    count_phase(2'd1, n);
    check("R8 total save cycles", 3 + n, 8);
    check("R8 act retargeted", int'(act_exc), 2);
    check("R8 vec retargeted", int'(vec_addr), 8);
    nmi_in = 1'b0; irq_in[5] = 1'b0;
    chain("R8 displaced line follows", 21);
    leave("R8 done", 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule